// File: doc/BRIEF.md
# Parity-Checked Memory Port with Read Retry

This block sits between a requester and a word-wide memory that is organised in byte lanes. On a write it computes one even-parity bit for each byte lane and stores these bits next to the data. On a read it checks every lane against its stored bit. A clean read completes at once. When any lane fails, the block records the first failing address and the set of failing lanes. It then reads the same word a second time before it decides anything.

If the second read is clean, the fault counts as transient. The original read completes with the data from the second read, and a saturating counter of transient faults goes up by one. If the second read fails as well, the fault counts as persistent. The block then raises a halt flag, drops the read, and accepts no further request until a synchronous reset. Requests use a valid/ready handshake, and ready is low while a read is checked or retried. The storage is a synchronous array. It has a fault-injection port that flips chosen stored bits either for the next read of one word only or permanently.

Top module: `parmem_guard`

## Requirements
- R1: A write accepted on a clock edge stores the data. A later clean read of that address returns it with `rsp_valid` high for exactly one cycle, visible after the second rising edge that follows the edge accepting the read.
- R2: `req_ready` is high only when the block is idle and not halted. It is low in the cycle after a read is accepted.
- R3: A parity mismatch on the first read of an access sets `err_log_valid`, provided the log is empty. It also records the address and a lane mask in which bit k marks byte lane k (data bits 8k+7..8k).
- R4: A mismatch on the first read triggers a second read of the same address on the following edge.
- R5: If the second read is clean, the response carries the second read's data and appears one cycle later than a clean read. `soft_errs` rises by one in the same cycle.
- R6: `soft_errs` saturates at its all-ones value and never wraps.
- R7: If the second read also fails, no response is given and `halt` rises and stays high. `req_ready` stays low until reset, and reset clears `halt`.
- R8: A one-shot injection corrupts only the next read of its address. A permanent injection stays until a write replaces the word. The injection mask uses bits [8*LANES-1:0] for the data and bit 8*LANES+k for the parity bit of lane k.
- R9: While the log is valid, later errors do not change it. Pulsing `err_log_clear` empties it, and the next error is captured.
- R10: After reset `req_ready`=1, `halt`=0, `rsp_valid`=0, `err_log_valid`=0 and `soft_errs`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 8*LANES | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 8*LANES | Read data |
| halt | output | 1 | Sticky persistent-fault halt |
| err_log_valid | output | 1 | Error log holds an entry |
| err_log_addr | output | ADDR_W | First failing address |
| err_log_lanes | output | LANES | Failing lanes of that access |
| err_log_clear | input | 1 | Empty the error log |
| soft_errs | output | CNT_W | Saturating transient-fault count |
| inj_en | input | 1 | Apply a fault injection |
| inj_hard | input | 1 | 1 = permanent, 0 = next read only |
| inj_addr | input | ADDR_W | Word to corrupt |
| inj_mask | input | 9*LANES | Bits to flip (data, then parity) |

## Verification
The assertions check several properties on every cycle. The halt flag is sticky and blocks ready. A response is a single-cycle pulse. Ready drops after a read is accepted. The retry targets the address that failed. The log stays unchanged until it is cleared. The counter only steps by one, only with a response, and holds at saturation. Only the bench scenarios can show the end-to-end results: read data matches what was written, response latency separates clean reads from retried ones, the captured address and lane mask are correct, one-shot and permanent injections behave differently, and reset recovers from a halt.

// File: rtl/parmem_pkg.sv
// Shared types for the parity-checked memory port.
// Assumes nothing beyond the byte-lane organisation of the data word.
package parmem_pkg;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a request
        ST_CHK1  = 2'd1,   // first read data present, checking
        ST_CHK2  = 2'd2,   // retry data present, checking
        ST_HALT  = 2'd3    // persistent fault, frozen until reset
    } pm_state_t;
endpackage

// File: rtl/parmem_par_gen.sv
// Even-parity generator: one bit per byte lane, equal to the XOR of that lane.
// Assumes the data word is LANES whole bytes, lane k at bits 8k+7..8k.
module parmem_par_gen #(
    parameter int LANES = 4
) (
    input  logic [LANES*parmem_pkg::LANE_W-1:0] data,
    output logic [LANES-1:0]                    par
);
    localparam int LW = parmem_pkg::LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // reduce one lane to its parity bit
        assign par[g] = ^data[g*LW +: LW];
    end
endmodule

// File: rtl/parmem_store.sv
// Synchronous word store with one-cycle registered read and fault injection.
// A permanent injection XORs the stored word in place. A one-shot injection
// arms a mask that corrupts only the next read of its address, and a write
// to that address disarms it. Assumes read and write never target the
// same cycle (the sequencer issues one access at a time).
module parmem_store #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word,
    input  logic              inj_en,
    input  logic              inj_hard,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [WORD_W-1:0] inj_mask
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic              os_armed;
    logic [ADDR_W-1:0] os_addr;
    logic [WORD_W-1:0] os_mask;
    logic              os_hit;

    assign os_hit = os_armed && rd_en && (rd_addr == os_addr);

    // array update: permanent injection first, a normal write overrides it
    always_ff @(posedge clk) begin
        if (inj_en && inj_hard) begin
            mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
        end
        if (wr_en) begin
            mem[wr_addr] <= wr_word;
        end
    end

    // registered read port, applying an armed one-shot mask
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_word <= os_hit ? (mem[rd_addr] ^ os_mask) : mem[rd_addr];
        end
    end

    // one-shot injection bookkeeping: arm, consume on read, drop on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            os_armed <= 1'b0;
            os_addr  <= '0;
            os_mask  <= '0;
        end else if (inj_en && !inj_hard) begin
            os_armed <= 1'b1;
            os_addr  <= inj_addr;
            os_mask  <= inj_mask;
        end else if (os_hit || (wr_en && wr_addr == os_addr)) begin
            os_armed <= 1'b0;
        end
    end
endmodule

// File: rtl/parmem_seq.sv
// Access sequencer: handshake, read check, single retry, fault classing,
// error log and saturating transient-fault counter.
// Assumes lane_bad is derived combinationally from the store's registered
// read word, so it is meaningful in ST_CHK1 and ST_CHK2.
module parmem_seq #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int CNT_W  = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic                                req_write,
    input  logic [ADDR_W-1:0]                   req_addr,
    output logic                                mem_wr_en,
    output logic                                mem_rd_en,
    output logic [ADDR_W-1:0]                   mem_rd_addr,
    input  logic [LANES*parmem_pkg::LANE_W-1:0] rd_data,
    input  logic [LANES-1:0]                    lane_bad,
    output logic                                first_bad,
    output logic                                rsp_valid,
    output logic [LANES*parmem_pkg::LANE_W-1:0] rsp_rdata,
    output logic                                halt,
    output logic                                err_log_valid,
    output logic [ADDR_W-1:0]                   err_log_addr,
    output logic [LANES-1:0]                    err_log_lanes,
    input  logic                                err_log_clear,
    output logic [CNT_W-1:0]                    soft_errs
);
    import parmem_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    pm_state_t         state;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;
    logic              any_bad;
    logic              good_done;
    logic              soft_done;

    assign any_bad     = |lane_bad;
    assign req_ready   = (state == ST_IDLE);
    assign halt        = (state == ST_HALT);
    assign accept      = req_ready && req_valid;
    assign mem_wr_en   = accept && req_write;
    assign first_bad   = (state == ST_CHK1) && any_bad;
    assign mem_rd_en   = (accept && !req_write) || first_bad;
    assign mem_rd_addr = (state == ST_IDLE) ? req_addr : addr_q;
    assign soft_done   = (state == ST_CHK2) && !any_bad;
    assign good_done   = ((state == ST_CHK1) && !any_bad) || soft_done;

    // state progression through check, retry and halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept && !req_write) begin
                    addr_q <= req_addr;
                    state  <= ST_CHK1;
                end
                ST_CHK1: state <= any_bad ? ST_CHK2 : ST_IDLE;
                ST_CHK2: state <= any_bad ? ST_HALT : ST_IDLE;
                ST_HALT: state <= ST_HALT;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // single-cycle response carrying checked data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= good_done;
            if (good_done) begin
                rsp_rdata <= rd_data;
            end
        end
    end

    // error log: first failure wins until cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_log_valid <= 1'b0;
            err_log_addr  <= '0;
            err_log_lanes <= '0;
        end else if (first_bad && (!err_log_valid || err_log_clear)) begin
            err_log_valid <= 1'b1;
            err_log_addr  <= addr_q;
            err_log_lanes <= lane_bad;
        end else if (err_log_clear) begin
            err_log_valid <= 1'b0;
        end
    end

    // saturating count of transient faults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_errs <= '0;
        end else if (soft_done && soft_errs != CNT_MAX) begin
            soft_errs <= soft_errs + 1'b1;
        end
    end
endmodule

// File: rtl/parmem_guard.sv
// Top: parity-protected memory port with retry-based fault classing.
// Stores data with per-lane even parity, checks each read, retries once on
// a mismatch and halts on a repeated failure. Assumes one outstanding access.
module parmem_guard #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LANES*8-1:0]    req_wdata,
    output logic                  rsp_valid,
    output logic [LANES*8-1:0]    rsp_rdata,
    output logic                  halt,
    output logic                  err_log_valid,
    output logic [ADDR_W-1:0]     err_log_addr,
    output logic [LANES-1:0]      err_log_lanes,
    input  logic                  err_log_clear,
    output logic [CNT_W-1:0]      soft_errs,
    input  logic                  inj_en,
    input  logic                  inj_hard,
    input  logic [ADDR_W-1:0]     inj_addr,
    input  logic [LANES*9-1:0]    inj_mask
);
    localparam int DATA_W = LANES * parmem_pkg::LANE_W;
    localparam int WORD_W = DATA_W + LANES;

    logic [LANES-1:0]  wr_par;
    logic [LANES-1:0]  rd_par_calc;
    logic [LANES-1:0]  lane_bad;
    logic [WORD_W-1:0] rd_word;
    logic              mem_wr_en;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic              first_bad;

    parmem_par_gen #(.LANES(LANES)) u_wr_par (
        .data (req_wdata),
        .par  (wr_par)
    );

    parmem_par_gen #(.LANES(LANES)) u_rd_par (
        .data (rd_word[DATA_W-1:0]),
        .par  (rd_par_calc)
    );

    assign lane_bad = rd_par_calc ^ rd_word[WORD_W-1:DATA_W];

    parmem_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mem_wr_en),
        .wr_addr  (req_addr),
        .wr_word  ({wr_par, req_wdata}),
        .rd_en    (mem_rd_en),
        .rd_addr  (mem_rd_addr),
        .rd_word  (rd_word),
        .inj_en   (inj_en),
        .inj_hard (inj_hard),
        .inj_addr (inj_addr),
        .inj_mask (inj_mask)
    );

    parmem_seq #(.ADDR_W(ADDR_W), .LANES(LANES), .CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .mem_wr_en     (mem_wr_en),
        .mem_rd_en     (mem_rd_en),
        .mem_rd_addr   (mem_rd_addr),
        .rd_data       (rd_word[DATA_W-1:0]),
        .lane_bad      (lane_bad),
        .first_bad     (first_bad),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .halt          (halt),
        .err_log_valid (err_log_valid),
        .err_log_addr  (err_log_addr),
        .err_log_lanes (err_log_lanes),
        .err_log_clear (err_log_clear),
        .soft_errs     (soft_errs)
    );
endmodule

// File: rtl/parmem_guard_chk.sv
// Checker for parmem_guard: temporal properties on ports and the
// sequencer-to-store read request. Bound to every parmem_guard instance.
module parmem_guard_chk #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic              rsp_valid,
    input logic              halt,
    input logic              err_log_valid,
    input logic              err_log_clear,
    input logic [ADDR_W-1:0] err_log_addr,
    input logic [LANES-1:0]  err_log_lanes,
    input logic [CNT_W-1:0]  soft_errs,
    input logic              first_bad,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr
);
    // R1: a response lasts a single cycle
    assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2: ready drops once a read is taken
    assert_busy_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> !req_ready);

    // R3, R9: log contents frozen while valid and not cleared
    assert_log_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_log_valid && !err_log_clear) |=>
            (err_log_valid && $stable(err_log_addr) && $stable(err_log_lanes)));

    // R4: a first-read mismatch issues a read of the same address
    assert_retry_same_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        first_bad |-> (mem_rd_en && mem_rd_addr == $past(mem_rd_addr)));

    // R5: the counter moves only by one and only with a response
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_errs != $past(soft_errs)) |->
            (soft_errs == CNT_W'($past(soft_errs) + 1'b1) && rsp_valid));

    // R6: a saturated counter stays saturated
    assert_count_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_errs == {CNT_W{1'b1}}) |=> (soft_errs == {CNT_W{1'b1}}));

    // R7: halt is sticky
    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    // R7: halt blocks requests
    assert_halt_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !req_ready);
endmodule

bind parmem_guard parmem_guard_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .CNT_W  (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .rsp_valid     (rsp_valid),
    .halt          (halt),
    .err_log_valid (err_log_valid),
    .err_log_clear (err_log_clear),
    .err_log_addr  (err_log_addr),
    .err_log_lanes (err_log_lanes),
    .soft_errs     (soft_errs),
    .first_bad     (first_bad),
    .mem_rd_en     (mem_rd_en),
    .mem_rd_addr   (mem_rd_addr)
);

// File: tb/sim_parmem_guard.sv
// Bench for parmem_guard: directed corner cases plus seeded random traffic,
// checked against a shadow copy of memory and a latency/counter model.
module sim_parmem_guard;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 6;
    localparam int LN   = 4;
    localparam int CW   = 4;
    localparam int DW   = LN * 8;
    localparam int WW   = LN * 9;
    localparam int NWORD = 1 << AW;
    localparam logic [CW-1:0] CMAX = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          halt;
    logic          err_log_valid;
    logic [AW-1:0] err_log_addr;
    logic [LN-1:0] err_log_lanes;
    logic          err_log_clear = 1'b0;
    logic [CW-1:0] soft_errs;
    logic          inj_en = 1'b0;
    logic          inj_hard = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [WW-1:0] inj_mask = '0;

    int nchk = 0;
    int nerr = 0;
    logic [DW-1:0] shadow [NWORD];
    logic [CW-1:0] exp_cnt = '0;
    bit            busy_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    parmem_guard #(.ADDR_W(AW), .LANES(LN), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .halt(halt),
        .err_log_valid(err_log_valid), .err_log_addr(err_log_addr),
        .err_log_lanes(err_log_lanes), .err_log_clear(err_log_clear),
        .soft_errs(soft_errs), .inj_en(inj_en), .inj_hard(inj_hard),
        .inj_addr(inj_addr), .inj_mask(inj_mask)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
        return (c == CMAX) ? c : c + 1'b1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = '0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        shadow[a] = d;
    endtask

    // returns latency in edges after acceptance, 0 if no response
    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0; d = '0;
        busy_seen = !req_ready;
        for (int i = 1; i <= 10; i++) begin
            if (rsp_valid) begin
                lat = i; d = rsp_rdata;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic inject(input logic [AW-1:0] a, input logic [WW-1:0] m, input bit hard);
        @(negedge clk);
        inj_en = 1'b1; inj_hard = hard; inj_addr = a; inj_mask = m;
        @(negedge clk);
        inj_en = 1'b0; inj_hard = 1'b0;
    endtask

    task automatic clear_log();
        @(negedge clk);
        err_log_clear = 1'b1;
        @(negedge clk);
        err_log_clear = 1'b0;
    endtask

    task automatic print_summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog (all R): actual=running expected=finished");
        print_summary();
        $finish;
    end

    initial begin : stim
        logic [DW-1:0] d;
        int lat;
        void'($urandom(32'd2024));

        do_reset();
        @(negedge clk);
        // R10: reset state
        check("R10 ready", req_ready, 1);
        check("R10 halt", halt, 0);
        check("R10 rsp_valid", rsp_valid, 0);
        check("R10 log_valid", err_log_valid, 0);
        check("R10 count", soft_errs, 0);

        for (int a = 0; a < NWORD; a++) do_write(a[AW-1:0], $urandom());

        // R1, R2: clean read
        do_read(6'd3, d, lat);
        check("R1 clean data", d, shadow[3]);
        check("R1 clean latency", lat, 2);
        check("R2 busy after accept", busy_seen, 1);

        // R5, R3: one-shot fault on lane 2 data bit 17
        inject(6'd5, 36'h1 << 17, 1'b0);
        do_read(6'd5, d, lat);
        exp_cnt = bump(exp_cnt);
        check("R5 soft data", d, shadow[5]);
        check("R5 soft latency", lat, 3);
        check("R5 count", soft_errs, exp_cnt);
        check("R3 log valid", err_log_valid, 1);
        check("R3 log addr", err_log_addr, 5);
        check("R3 log lanes", err_log_lanes, 4'b0100);
        // R8: one-shot gone on the next read
        do_read(6'd5, d, lat);
        check("R8 one-shot consumed latency", lat, 2);
        check("R8 one-shot consumed data", d, shadow[5]);

        // R9: parity bit of lane 0 at another address does not overwrite log
        inject(6'd9, 36'h1 << 32, 1'b0);
        do_read(6'd9, d, lat);
        exp_cnt = bump(exp_cnt);
        check("R5 parity-bit fault latency", lat, 3);
        check("R9 log held addr", err_log_addr, 5);
        check("R9 log held lanes", err_log_lanes, 4'b0100);
        clear_log();
        check("R9 log cleared", err_log_valid, 0);
        // R3: two lanes (bits 8 and 30) captured after clear
        inject(6'd12, (36'h1 << 8) | (36'h1 << 30), 1'b0);
        do_read(6'd12, d, lat);
        exp_cnt = bump(exp_cnt);
        check("R9 recapture addr", err_log_addr, 12);
        check("R3 two-lane mask", err_log_lanes, 4'b1010);
        check("R5 two-lane data", d, shadow[12]);

        // R6: drive the counter into saturation
        for (int k = 0; k < 14; k++) begin
            inject(6'd20, 36'h1 << (k % 36), 1'b0);
            do_read(6'd20, d, lat);
            exp_cnt = bump(exp_cnt);
        end
        check("R6 saturated", soft_errs, CMAX);
        check("R6 model agrees", exp_cnt, CMAX);

        // seeded random traffic with occasional one-shot faults
        for (int it = 0; it < 300; it++) begin
            logic [AW-1:0] a;
            a = AW'($urandom % NWORD);
            if ($urandom % 3 == 0) begin
                do_write(a, $urandom());
            end else begin
                bit f;
                f = ($urandom % 4 == 0);
                if (f) inject(a, 36'h1 << ($urandom % WW), 1'b0);
                do_read(a, d, lat);
                if (f) exp_cnt = bump(exp_cnt);
                check("R1 random data", d, shadow[a]);
                check("R5 random latency", lat, f ? 3 : 2);
                check("R6 random count", soft_errs, exp_cnt);
            end
        end

        // R8: permanent fault is replaced by a write
        inject(6'd40, 36'h1 << 1, 1'b1);
        do_write(6'd40, 32'hA5A5_0F0F);
        do_read(6'd40, d, lat);
        check("R8 overwrite clears fault latency", lat, 2);
        check("R8 overwrite data", d, 32'hA5A5_0F0F);

        // R7: persistent fault halts
        clear_log();
        inject(6'd30, 36'h1 << 3, 1'b1);
        do_read(6'd30, d, lat);
        check("R7 no response", lat, 0);
        check("R7 halt", halt, 1);
        check("R7 ready low", req_ready, 0);
        check("R3 hard log addr", err_log_addr, 30);
        check("R3 hard log lanes", err_log_lanes, 4'b0001);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd1; req_wdata = 32'h1234;
        repeat (5) @(negedge clk);
        check("R7 still blocked", req_ready, 0);
        check("R7 still halted", halt, 1);
        req_valid = 1'b0; req_write = 1'b0;

        // R7: reset recovers
        do_reset();
        @(negedge clk);
        check("R7 reset clears halt", halt, 0);
        check("R10 ready after reset", req_ready, 1);
        do_write(6'd30, 32'hCAFE_0001);
        do_read(6'd30, d, lat);
        check("R7 service after reset data", d, 32'hCAFE_0001);
        check("R7 service after reset latency", lat, 2);
        // R1: address 1 untouched by the blocked write
        do_read(6'd1, d, lat);
        check("R7 blocked write had no effect", d, shadow[1]);

        print_summary();
        $finish;
    end
endmodule